// File: doc/BRIEF.md
# Reed-Solomon Correction Byte Mapper

This block sits after a Reed-Solomon decoder for a NAND page and applies the decoder's results to a byte buffer. The buffer is one contiguous byte space: 2048 data bytes, then the spare bytes. Codeword symbols are 12 bits wide, and every pair of symbols occupies three bytes. So a symbol either starts on a byte boundary or starts in the middle of a byte, and one symbol sits across the last data byte and the first spare byte. For each (position, pattern) pair it receives, the block performs one or two read-modify-write byte updates. It also detects the cases that cannot be corrected.

Each page begins with a start pulse, which clears the corrected-symbol count and the uncorrectable flag. Corrections arrive with a valid/ready handshake and are handled strictly one after another. Each byte update is a read cycle followed by a write cycle to the same address, and the buffer returns read data one cycle after the read. After a page has been marked uncorrectable, the block still accepts entries for that page but touches the buffer no more. The block also splits four 32-bit syndrome words into eight 12-bit syndromes for the decoder.

Top module: `rs_fix_mapper`

## Requirements
- R1: Syndrome k (k = 0..7) on `syn_o[12k+11:12k]` equals bits 11:0 of syndrome word k/2 when k is even, and bits 27:16 of that word when k is odd. Syndrome word j is `syn_regs_i[32j+31:32j]`.
- R2: Position 0 with a pattern of 0xFF or less makes exactly one update: byte 0 is XORed with the low 8 bits of the pattern.
- R3: Position 0 with a pattern above 0xFF sets `uncorr_o` and makes no buffer access.
- R4: An odd position p makes two updates. Byte (3p-1)/2 is XORed with pattern bits 11:4. The byte after it is XORed with pattern bits 3:0 placed in the upper nibble.
- R5: An even position p > 0 makes two updates. Byte 3p/2-1 is XORed with pattern bits 11:8 placed in the lower nibble. Byte 3p/2 is XORed with pattern bits 7:0.
- R6: Position 1365 updates data byte 2047 with pattern bits 11:4 and the upper nibble of spare byte 0 (buffer byte 2048) with pattern bits 3:0. Positions above 1365 follow R4/R5 inside the spare area.
- R7: A position above `MAX_POS` (1374) sets `uncorr_o` and makes no buffer access.
- R8: Every update is a read of one address followed in the next cycle by a write of the read byte XOR the mask to that address. Entries are handled in arrival order, and `err_ready_o` is low while an entry is in progress.
- R9: Each correctable entry increments `corr_count_o` in the cycle after it is accepted. `start_i` clears the count and `uncorr_o`.
- R10: Once `uncorr_o` is set, further entries of the page make no buffer access and leave `corr_count_o` unchanged.
- R11: An entry that arrives when `corr_count_o` already equals `MAX_CORR` (4) sets `uncorr_o` and makes no buffer access.
- R12: After reset `err_ready_o` is 1, `corr_count_o` is 0, `uncorr_o` is 0, and neither read nor write is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new page: clears count and flag |
| err_valid_i | input | 1 | Correction entry valid |
| err_pos_i | input | 11 | Symbol position of the entry |
| err_pat_i | input | 12 | 12-bit error pattern |
| err_ready_o | output | 1 | Block can accept an entry |
| buf_rd_en_o | output | 1 | Buffer read strobe |
| buf_wr_en_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | 12 | Buffer byte address |
| buf_wdata_o | output | 8 | Corrected byte to write |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after the read strobe |
| corr_count_o | output | 3 | Symbols corrected in this page |
| uncorr_o | output | 1 | Page marked uncorrectable |
| syn_regs_i | input | 128 | Four 32-bit syndrome words |
| syn_o | output | 96 | Eight unpacked 12-bit syndromes |

## Verification
Some properties are checked on every cycle:
- each write is preceded by a read of the same address;
- read and write never coincide, and the handshake is closed while an access is under way;
- no access happens while the page is uncorrectable;
- the count stays within `MAX_CORR` and moves only on an accepted entry or on start;
- addresses stay inside the buffer.

The byte mapping itself can only be shown by the bench's scenarios. The bench sweeps every position from 0 to 1374 against an arithmetic model of the three-byte packing, including the symbol that crosses the boundary. Directed pages cover the rejection cases, the limit of four corrections, the syndrome split and the clearing by start.

// File: rtl/rsm_pkg.sv
// Package: shared constants and the sequencer state type for the
// correction byte mapper. Assumes 12-bit symbols packed two per three bytes.
package rsm_pkg;
    localparam int SYM_W      = 12;
    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int SYN_WORD_W = 32;
    localparam int SYN_HI_LSB = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_WR0,
        ST_RD1,
        ST_WR1
    } rsm_state_e;
endpackage

// File: rtl/rsm_syn_unpack.sv
// Module: splits packed 32-bit syndrome words into 12-bit syndromes.
// Assumes two syndromes per word: the even one at bit 0, the odd one at bit 16.
module rsm_syn_unpack
    import rsm_pkg::*;
#(
    parameter int NUM_SYN = 8,
    localparam int NUM_WORDS = NUM_SYN / 2
) (
    input  logic [NUM_WORDS*SYN_WORD_W-1:0] words_i,
    output logic [NUM_SYN*SYM_W-1:0]        syn_o
);
    // One lane pair per syndrome word.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [SYN_WORD_W-1:0] word;
        assign word = words_i[w*SYN_WORD_W +: SYN_WORD_W];
        assign syn_o[(2*w)*SYM_W   +: SYM_W] = word[0 +: SYM_W];
        assign syn_o[(2*w+1)*SYM_W +: SYM_W] = word[SYN_HI_LSB +: SYM_W];
    end
endmodule

// File: rtl/rsm_locate.sv
// Module: turns a symbol position and pattern into byte addresses and XOR
// masks. Combinational. Assumes a contiguous buffer (data then spare), so the
// symbol crossing the data/spare boundary needs no special case.
module rsm_locate
    import rsm_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int MAX_POS = 1374,
    localparam int POS_W  = ADDR_W - 1
) (
    input  logic [POS_W-1:0]  pos_i,
    input  logic [SYM_W-1:0]  pat_i,
    output logic              bad_o,
    output logic              two_o,
    output logic [ADDR_W-1:0] addr0_o,
    output logic [BYTE_W-1:0] mask0_o,
    output logic [ADDR_W-1:0] addr1_o,
    output logic [BYTE_W-1:0] mask1_o
);
    logic [ADDR_W:0]   trip;
    logic [ADDR_W-1:0] half;
    logic              pos_zero;
    logic              pos_odd;
    logic              out_of_range;

    // Byte offset of the symbol: floor(3p/2).
    always_comb begin
        trip         = {1'b0, pos_i, 1'b0} + {2'b00, pos_i};
        half         = trip[ADDR_W:1];
        pos_zero     = (pos_i == '0);
        pos_odd      = pos_i[0];
        out_of_range = (pos_i > POS_W'(MAX_POS));
    end

    // Choose the update pair for the three symbol alignments.
    always_comb begin
        bad_o   = out_of_range;
        two_o   = 1'b1;
        addr0_o = half;
        addr1_o = half + ADDR_W'(1);
        mask0_o = pat_i[SYM_W-1 -: BYTE_W];
        mask1_o = {pat_i[NIB_W-1:0], {NIB_W{1'b0}}};
        if (pos_zero) begin
            bad_o   = |pat_i[SYM_W-1:BYTE_W];
            two_o   = 1'b0;
            addr0_o = '0;
            mask0_o = pat_i[BYTE_W-1:0];
            addr1_o = '0;
            mask1_o = '0;
        end else if (!pos_odd) begin
            addr0_o = half - ADDR_W'(1);
            addr1_o = half;
            mask0_o = {{NIB_W{1'b0}}, pat_i[SYM_W-1:BYTE_W]};
            mask1_o = pat_i[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/rsm_rmw_seq.sv
// Module: accepts one correction at a time and runs one or two
// read-modify-write byte updates. Keeps the per-page count and the
// uncorrectable flag. Assumes the buffer returns read data one cycle after
// the read strobe.
module rsm_rmw_seq
    import rsm_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int MAX_CORR = 4,
    localparam int CNT_W   = $clog2(MAX_CORR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    output logic              ready_o,
    input  logic              bad_i,
    input  logic              two_i,
    input  logic [ADDR_W-1:0] addr0_i,
    input  logic [BYTE_W-1:0] mask0_i,
    input  logic [ADDR_W-1:0] addr1_i,
    input  logic [BYTE_W-1:0] mask1_i,
    output logic              rd_en_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              uncorr_o
);
    rsm_state_e        state_q;
    logic              two_q;
    logic [ADDR_W-1:0] addr0_q, addr1_q;
    logic [BYTE_W-1:0] mask0_q, mask1_q;
    logic [CNT_W-1:0]  count_q;
    logic              uncorr_q;
    logic [CNT_W-1:0]  base_cnt;
    logic              base_unc;
    logic              accept;

    // Page state as seen by an entry in this cycle (start clears first).
    always_comb begin
        base_cnt = start_i ? '0 : count_q;
        base_unc = start_i ? 1'b0 : uncorr_q;
        accept   = valid_i && (state_q == ST_IDLE);
    end

    // Sequencer, captured update plan and page bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            two_q    <= 1'b0;
            addr0_q  <= '0;
            addr1_q  <= '0;
            mask0_q  <= '0;
            mask1_q  <= '0;
            count_q  <= '0;
            uncorr_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    count_q  <= base_cnt;
                    uncorr_q <= base_unc;
                    if (accept && !base_unc) begin
                        if (bad_i || base_cnt == CNT_W'(MAX_CORR)) begin
                            uncorr_q <= 1'b1;
                        end else begin
                            count_q <= base_cnt + CNT_W'(1);
                            two_q   <= two_i;
                            addr0_q <= addr0_i;
                            addr1_q <= addr1_i;
                            mask0_q <= mask0_i;
                            mask1_q <= mask1_i;
                            state_q <= ST_RD0;
                        end
                    end
                end
                ST_RD0:  state_q <= ST_WR0;
                ST_WR0:  state_q <= two_q ? ST_RD1 : ST_IDLE;
                ST_RD1:  state_q <= ST_WR1;
                ST_WR1:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Buffer strobes, address and merged write data per state.
    always_comb begin
        rd_en_o = (state_q == ST_RD0) || (state_q == ST_RD1);
        wr_en_o = (state_q == ST_WR0) || (state_q == ST_WR1);
        if (state_q == ST_RD1 || state_q == ST_WR1) begin
            addr_o  = addr1_q;
            wdata_o = rdata_i ^ mask1_q;
        end else begin
            addr_o  = addr0_q;
            wdata_o = rdata_i ^ mask0_q;
        end
    end

    // Handshake and status outputs.
    always_comb begin
        ready_o  = (state_q == ST_IDLE);
        count_o  = count_q;
        uncorr_o = uncorr_q;
    end
endmodule

// File: rtl/rs_fix_mapper.sv
// Module: top of the correction byte mapper. Maps (position, pattern) pairs
// onto a byte buffer through read-modify-write updates, and unpacks the
// syndrome words. Assumes positions are counted from symbol 0 at byte 0.
module rs_fix_mapper
    import rsm_pkg::*;
#(
    parameter int BUF_BYTES = 2112,
    parameter int MAX_POS   = 1374,
    parameter int MAX_CORR  = 4,
    parameter int NUM_SYN   = 8,
    localparam int ADDR_W    = $clog2(BUF_BYTES),
    localparam int POS_W     = ADDR_W - 1,
    localparam int CNT_W     = $clog2(MAX_CORR + 1),
    localparam int NUM_WORDS = NUM_SYN / 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          err_valid_i,
    input  logic [POS_W-1:0]              err_pos_i,
    input  logic [SYM_W-1:0]              err_pat_i,
    output logic                          err_ready_o,
    output logic                          buf_rd_en_o,
    output logic                          buf_wr_en_o,
    output logic [ADDR_W-1:0]             buf_addr_o,
    output logic [BYTE_W-1:0]             buf_wdata_o,
    input  logic [BYTE_W-1:0]             buf_rdata_i,
    output logic [CNT_W-1:0]              corr_count_o,
    output logic                          uncorr_o,
    input  logic [NUM_WORDS*SYN_WORD_W-1:0] syn_regs_i,
    output logic [NUM_SYN*SYM_W-1:0]      syn_o
);
    logic              loc_bad, loc_two;
    logic [ADDR_W-1:0] loc_a0, loc_a1;
    logic [BYTE_W-1:0] loc_m0, loc_m1;

    rsm_syn_unpack #(.NUM_SYN(NUM_SYN)) u_syn (
        .words_i (syn_regs_i),
        .syn_o   (syn_o)
    );

    rsm_locate #(.ADDR_W(ADDR_W), .MAX_POS(MAX_POS)) u_loc (
        .pos_i   (err_pos_i),
        .pat_i   (err_pat_i),
        .bad_o   (loc_bad),
        .two_o   (loc_two),
        .addr0_o (loc_a0),
        .mask0_o (loc_m0),
        .addr1_o (loc_a1),
        .mask1_o (loc_m1)
    );

    rsm_rmw_seq #(.ADDR_W(ADDR_W), .MAX_CORR(MAX_CORR)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .valid_i  (err_valid_i),
        .ready_o  (err_ready_o),
        .bad_i    (loc_bad),
        .two_i    (loc_two),
        .addr0_i  (loc_a0),
        .mask0_i  (loc_m0),
        .addr1_i  (loc_a1),
        .mask1_i  (loc_m1),
        .rd_en_o  (buf_rd_en_o),
        .wr_en_o  (buf_wr_en_o),
        .addr_o   (buf_addr_o),
        .wdata_o  (buf_wdata_o),
        .rdata_i  (buf_rdata_i),
        .count_o  (corr_count_o),
        .uncorr_o (uncorr_o)
    );
endmodule

// File: rtl/rsm_checker.sv
// Module: cycle-level properties of the correction byte mapper, attached to
// the top by bind. Observes ports only.
module rsm_checker #(
    parameter int BUF_BYTES = 2112,
    parameter int MAX_CORR  = 4,
    parameter int ADDR_W    = 12,
    parameter int CNT_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              err_valid_i,
    input logic              err_ready_o,
    input logic              buf_rd_en_o,
    input logic              buf_wr_en_o,
    input logic [ADDR_W-1:0] buf_addr_o,
    input logic [CNT_W-1:0]  corr_count_o,
    input logic              uncorr_o
);
    // R8: a write always follows a read of the same address.
    p_wr_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en_o |-> ($past(buf_rd_en_o) && $past(buf_addr_o) == buf_addr_o));

    // R8: read and write never in the same cycle.
    p_no_rd_wr_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en_o && buf_wr_en_o));

    // R8: handshake closed while an access is under way.
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en_o || buf_wr_en_o) |-> !err_ready_o);

    // R10: no buffer access while the page is uncorrectable.
    p_no_access_uncorr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en_o || buf_wr_en_o) |-> !uncorr_o);

    // R11: count never exceeds the correction limit.
    p_count_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        corr_count_o <= CNT_W'(MAX_CORR));

    // R9: count moves only on an accepted entry or a start.
    p_count_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(err_valid_i && err_ready_o) && !start_i) |=> $stable(corr_count_o));

    // R6: every access stays inside the buffer.
    p_addr_in_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en_o || buf_wr_en_o) |-> (int'(buf_addr_o) < BUF_BYTES));
endmodule

bind rs_fix_mapper rsm_checker #(
    .BUF_BYTES (BUF_BYTES),
    .MAX_CORR  (MAX_CORR),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W)
) u_rsm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .err_valid_i  (err_valid_i),
    .err_ready_o  (err_ready_o),
    .buf_rd_en_o  (buf_rd_en_o),
    .buf_wr_en_o  (buf_wr_en_o),
    .buf_addr_o   (buf_addr_o),
    .corr_count_o (corr_count_o),
    .uncorr_o     (uncorr_o)
);

// File: tb/test_rs_fix_mapper.sv
module test_rs_fix_mapper;
    localparam int BUF_BYTES = 2112;
    localparam int MAX_POS   = 1374;
    localparam int MAX_CORR  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        err_valid_i = 1'b0;
    logic [10:0] err_pos_i = '0;
    logic [11:0] err_pat_i = '0;
    logic        err_ready_o;
    logic        buf_rd_en_o, buf_wr_en_o;
    logic [11:0] buf_addr_o;
    logic [7:0]  buf_wdata_o;
    logic [7:0]  buf_rdata_i = '0;
    logic [2:0]  corr_count_o;
    logic        uncorr_o;
    logic [127:0] syn_regs_i = '0;
    logic [95:0]  syn_o;

    logic [7:0] mem [BUF_BYTES];
    logic [7:0] expm [BUF_BYTES];
    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    rs_fix_mapper i_rs_fix_mapper (.*);

    // Buffer model: one-cycle read latency, write on the strobe.
    always @(posedge clk) begin
        if (buf_rd_en_o) buf_rdata_i <= mem[buf_addr_o];
        if (buf_wr_en_o) begin
            mem[buf_addr_o] <= buf_wdata_o;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: cycles act=%0d exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (!err_ready_o) @(negedge clk);
    endtask

    // Send one entry, return after it has fully completed.
    task automatic send(input int pos, input int pat);
        @(negedge clk);
        while (!err_ready_o) @(negedge clk);
        err_pos_i   = 11'(pos);
        err_pat_i   = 12'(pat);
        err_valid_i = 1'b1;
        @(negedge clk);
        err_valid_i = 1'b0;
        wait_idle();
        @(negedge clk);
    endtask

    // Expected effect of one correctable entry, from the mapping rules.
    task automatic model(input int p, input int pat, output int a0, output int a1, output int n);
        if (p == 0) begin
            a0 = 0; a1 = 0; n = 1;
            expm[0] = expm[0] ^ 8'(pat & 8'hFF);
        end else if (p % 2 == 1) begin
            a0 = (3 * p - 1) / 2; a1 = a0 + 1; n = 2;
            expm[a0] = expm[a0] ^ 8'(pat >> 4);
            expm[a1] = expm[a1] ^ 8'((pat & 4'hF) << 4);
        end else begin
            a0 = 3 * p / 2 - 1; a1 = a0 + 1; n = 2;
            expm[a0] = expm[a0] ^ 8'(pat >> 8);
            expm[a1] = expm[a1] ^ 8'(pat & 8'hFF);
        end
    endtask

    task automatic syn_case(input logic [127:0] w);
        syn_regs_i = w;
        #1;
        for (int k = 0; k < 8; k++) begin
            int e;
            e = int'(w[32*(k/2) +: 32] >> ((k % 2) * 16)) & 12'hFFF;
            chk(int'(syn_o[12*k +: 12]) == e, "R1 syndrome split", int'(syn_o[12*k +: 12]), e);
        end
    endtask

    initial begin
        int a0, a1, n, w0, pat, req_ok;
        for (int i = 0; i < BUF_BYTES; i++) begin
            mem[i]  = 8'((i * 7 + 3) & 8'hFF);
            expm[i] = 8'((i * 7 + 3) & 8'hFF);
        end
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(err_ready_o == 1'b1, "R12 ready", int'(err_ready_o), 1);
        chk(corr_count_o == 3'd0, "R12 count", int'(corr_count_o), 0);
        chk(uncorr_o == 1'b0, "R12 uncorr", int'(uncorr_o), 0);
        chk(!buf_rd_en_o && !buf_wr_en_o, "R12 strobes", int'({buf_rd_en_o, buf_wr_en_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: syndrome split under several word patterns
        syn_case({32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678, 32'h9ABC_DEF0});
        syn_case({32'h0ABC_0123, 32'hF00F_0FF0, 32'h8001_0800, 32'h7FFE_F7FF});

        // Full sweep over every valid position, four entries per page.
        for (int p = 0; p <= MAX_POS; p++) begin
            string tag;
            pat = (p == 0) ? 12'h0C3 : ((p * 613 + 12'h5A3) & 12'hFFF);
            if (p % MAX_CORR == 0) do_start();
            w0 = wr_cnt;
            send(p, pat);
            model(p, pat, a0, a1, n);
            if (p == 0) tag = "R2 pos0";
            else if (p == 1365) tag = "R6 boundary";
            else if (p > 1365) tag = (p % 2 == 1) ? "R6 spare odd" : "R6 spare even";
            else tag = (p % 2 == 1) ? "R4 odd" : "R5 even";
            req_ok = (mem[a0] == expm[a0]) && (mem[a1] == expm[a1]);
            chk(req_ok != 0, tag, int'({mem[a0], mem[a1]}), int'({expm[a0], expm[a1]}));
            chk(wr_cnt - w0 == n, "R8 update count", wr_cnt - w0, n);
            chk(int'(corr_count_o) == (p % MAX_CORR) + 1, "R9 count", int'(corr_count_o),
                (p % MAX_CORR) + 1);
        end
        begin
            int bad_at;
            bad_at = -1;
            for (int i = 0; i < BUF_BYTES; i++)
                if (mem[i] != expm[i] && bad_at < 0) bad_at = i;
            chk(bad_at < 0, "R8 whole buffer after sweep", bad_at, -1);
        end

        // R3: position 0 with a wide pattern
        do_start();
        w0 = wr_cnt;
        send(0, 12'h1FF);
        chk(uncorr_o == 1'b1, "R3 uncorr", int'(uncorr_o), 1);
        chk(wr_cnt == w0, "R3 no write", wr_cnt - w0, 0);
        chk(mem[0] == expm[0], "R3 byte0 kept", int'(mem[0]), int'(expm[0]));

        // R10: later good entry in same page is suppressed
        w0 = wr_cnt;
        send(30, 12'hABC);
        chk(wr_cnt == w0, "R10 no write", wr_cnt - w0, 0);
        chk(corr_count_o == 3'd0, "R10 count frozen", int'(corr_count_o), 0);
        chk(mem[44] == expm[44] && mem[45] == expm[45], "R10 bytes kept",
            int'({mem[44], mem[45]}), int'({expm[44], expm[45]}));

        // R9: start clears flag and count
        do_start();
        chk(uncorr_o == 1'b0, "R9 start clears flag", int'(uncorr_o), 0);
        chk(corr_count_o == 3'd0, "R9 start clears count", int'(corr_count_o), 0);

        // R7: position past the limit
        w0 = wr_cnt;
        send(MAX_POS + 1, 12'h123);
        chk(uncorr_o == 1'b1, "R7 uncorr", int'(uncorr_o), 1);
        chk(wr_cnt == w0, "R7 no write", wr_cnt - w0, 0);
        do_start();
        send(2047, 12'h001);
        chk(uncorr_o == 1'b1, "R7 uncorr max", int'(uncorr_o), 1);

        // R11: fifth entry in a page; also overlapping bytes in order (R8)
        do_start();
        for (int q = 0; q < MAX_CORR; q++) begin
            send(5 + q, 12'h3C5 + q);
            model(5 + q, 12'h3C5 + q, a0, a1, n);
        end
        chk(mem[7] == expm[7] && mem[8] == expm[8] && mem[9] == expm[9],
            "R8 shared bytes", int'({mem[7], mem[8], mem[9]}), int'({expm[7], expm[8], expm[9]}));
        w0 = wr_cnt;
        send(20, 12'h777);
        chk(uncorr_o == 1'b1, "R11 limit uncorr", int'(uncorr_o), 1);
        chk(corr_count_o == 3'(MAX_CORR), "R11 count", int'(corr_count_o), MAX_CORR);
        chk(wr_cnt == w0, "R11 no write", wr_cnt - w0, 0);

        summary();
        $finish;
    end
endmodule